// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register front end of a multi-timer event timer, together with its free-running 32-bit main counter. A single access port carries a valid strobe, a write flag, a byte offset, 64-bit write data and an access size in bytes. Accesses of 4 or 8 bytes that are naturally aligned are decoded against a 64-bit register space. A 4-byte access selects one half of a 64-bit register through a lane mask, and a write changes only the bits under that mask. Read data comes back one cycle after the request. The block itself holds three registers: a read-only capabilities word, a global configuration register and the main counter. Registers that belong to the individual timer channels are passed on to them. A write to one of them leaves as a one-cycle channel write pulse that carries a timer index, a kind (configuration or comparator), the lane-aligned data and the mask. A read of one of them presents the index and kind combinationally and returns the data the channel supplies.

The counter is run by a two-state machine. In CNT_HALTED the counter holds its value. In CNT_RUNNING it adds one on every cycle in which the external tick-enable input is high. The tick input lets the nominal 2^24 Hz rate be derived outside the block. The START transition goes from CNT_HALTED to CNT_RUNNING and is taken when a configuration write sets the enable bit. The STOP transition goes from CNT_RUNNING to CNT_HALTED and is taken when a configuration write clears that bit. Every other cycle keeps the current state (HOLD). The counter value and the running state are also brought out so that the timer channels can compare against them.

Register offsets:
- 0x000: capabilities.
- 0x010: configuration.
- 0x0F0: main counter.
- Timer channel n: configuration at 0x100 + 32·n, comparator at 0x108 + 32·n.

Top module: `evt_timer_regs`

## Requirements
- R1: Only accesses with acc_size equal to 4 or 8 are accepted. A write of any other size changes nothing and forwards nothing. A read of any other size returns zero.
- R2: An access whose offset is not a multiple of its size is dropped. A dropped write changes nothing and forwards nothing. A dropped read returns zero.
- R3: A 4-byte access with offset bit 2 set targets bits 63:32. The write data and the mask are shifted up by 32, and a read returns bits 63:32 in acc_rdata[31:0]. A 4-byte access with offset bit 2 clear targets bits 31:0. Every 4-byte read is zero-extended to 64 bits.
- R4: A write changes only the register bits under its lane mask: new = (old & ~mask) | (data & mask). A 4-byte write to the upper half of the configuration register or of the counter leaves the enable bit and the counter value unchanged.
- R5: The capabilities word at offset 0x000 reads as follows:
  - bits 63:32: the tick period in femtoseconds, 10^15 / 2^24 = 59604644.
  - bits 31:16: 0x8086.
  - bit 13: 0, which marks a 32-bit counter.
  - bits 12:8: the number of timers minus one, which is 7.
  - bits 7:0: 1.
  - All other bits: 0.
- R6: Bit 0 of the configuration register at offset 0x010 is the counter enable and reads back as written. Bit 1, the legacy routing bit, and all other bits always read 0.
- R7: In CNT_RUNNING the counter adds 1 in every cycle with tick_en high and wraps from 0xFFFFFFFF to 0. A read at 0x0F0 returns the counter value from before the edge that samples the request, zero-extended to 64 bits.
- R8: A write to the counter at 0x0F0 loads the merged value at the next edge. The load takes priority over a tick in the same cycle, and counting continues from the loaded value.
- R9: A configuration write takes the START or STOP transition at the edge that samples it. A tick in that same cycle follows the state from before the write. In CNT_HALTED the counter holds its value whatever tick_en does.
- R10: An accepted write to the configuration (0x100 + 32·n) or comparator (0x108 + 32·n) register of timer n < 8 raises ch_wr_valid for one cycle after the request. ch_wr_cfg is 1 for configuration and 0 for comparator. ch_wr_idx, ch_wr_data and ch_wr_mask carry n and the lane-aligned data and mask.
- R11: While a request addresses a timer register, ch_rd_idx and ch_rd_cfg name it. A read of that register returns ch_rd_data, shaped as in R3.
- R12: Reads of unmapped offsets return zero. Unmapped offsets include 0x008, 0x110 + 32·n and offsets at or beyond 0x200. Writes to unmapped offsets change nothing and forward nothing.
- R13: After reset the counter is 0 and the state is CNT_HALTED, with acc_rvalid and ch_wr_valid low. acc_rvalid pulses exactly one cycle after each read request, dropped or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick pulse |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset in the register space |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read |
| acc_rdata | output | 64 | Read data |
| ch_rd_idx | output | 3 | Timer addressed by the current request |
| ch_rd_cfg | output | 1 | 1 = configuration, 0 = comparator register |
| ch_rd_data | input | 64 | Register value supplied by the addressed channel |
| ch_wr_valid | output | 1 | Channel write pulse |
| ch_wr_idx | output | 3 | Target timer of the channel write |
| ch_wr_cfg | output | 1 | 1 = configuration, 0 = comparator |
| ch_wr_data | output | 64 | Lane-aligned write data |
| ch_wr_mask | output | 64 | Lane mask of the write |
| cnt_value | output | 32 | Main counter value |
| cnt_running | output | 1 | Counter is in CNT_RUNNING |

## Verification
Two pairs of events can share a clock edge. A counter load can land in the same cycle as a tick, and a STOP or START configuration write can land in the same cycle as a tick. The bench provokes both by holding tick_en high on every cycle while it issues those writes. A behavioural model applies the rules of R8 and R9 to decide the outcome: the load wins over the tick, and the state from before the write decides whether the tick counts. The model checks the counter and running outputs against that outcome on every clock.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    // Register classes produced by the offset decoder
    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CAPS,
        RGN_GCFG,
        RGN_COUNT,
        RGN_TCFG,
        RGN_TCMP
    } rgn_e;

    // Main counter state machine
    typedef enum logic {
        CNT_HALTED,
        CNT_RUNNING
    } cnt_state_e;

    // Offsets of the 64-bit registers (byte addresses, qword aligned)
    localparam int OFS_CAPS     = 'h000;
    localparam int OFS_GCFG     = 'h010;
    localparam int OFS_COUNT    = 'h0F0;
    localparam int OFS_TMR_BASE = 'h100;
    localparam int TMR_STRIDE   = 32;
    localparam int TMR_CMP_OFS  = 8;

endpackage

// File: rtl/evt_timer_decode.sv
module evt_timer_decode
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int N_TIMERS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [63:0]       wdata,
    output logic              acc_ok,
    output rgn_e              rgn,
    output logic [IDX_W-1:0]  tmr_idx,
    output logic              is_word,
    output logic              hi_half,
    output logic [63:0]       lane_data,
    output logic [63:0]       lane_mask
);

    localparam int TMR_END   = OFS_TMR_BASE + TMR_STRIDE * N_TIMERS;
    localparam int STRIDE_SH = $clog2(TMR_STRIDE);
    localparam int CMP_SLOT  = TMR_CMP_OFS / 8;

    logic              size_ok;
    logic              align_ok;
    logic [ADDR_W-1:0] qaddr;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] slot;
    logic [1:0]        sub;

    // Size and natural alignment
    always_comb begin
        size_ok = (size == 4'd4) || (size == 4'd8);
        if (size == 4'd8) begin
            align_ok = (addr[2:0] == 3'b000);
        end else begin
            align_ok = (addr[1:0] == 2'b00);
        end
    end

    assign acc_ok  = size_ok && align_ok;
    assign is_word = (size == 4'd8);
    assign hi_half = (size == 4'd4) && addr[2];

    // Offset decode on the qword address
    assign qaddr = {addr[ADDR_W-1:3], 3'b000};
    assign rel   = qaddr - ADDR_W'(OFS_TMR_BASE);
    assign slot  = rel >> STRIDE_SH;
    assign sub   = rel[4:3];

    always_comb begin
        rgn     = RGN_NONE;
        tmr_idx = '0;
        if (int'(qaddr) == OFS_CAPS) begin
            rgn = RGN_CAPS;
        end else if (int'(qaddr) == OFS_GCFG) begin
            rgn = RGN_GCFG;
        end else if (int'(qaddr) == OFS_COUNT) begin
            rgn = RGN_COUNT;
        end else if (int'(qaddr) >= OFS_TMR_BASE && int'(qaddr) < TMR_END) begin
            tmr_idx = IDX_W'(slot);
            if (sub == 2'd0) begin
                rgn = RGN_TCFG;
            end else if (int'(sub) == CMP_SLOT) begin
                rgn = RGN_TCMP;
            end else begin
                rgn = RGN_NONE;
            end
        end
    end

    // Lane placement of write data and mask
    always_comb begin
        if (size == 4'd8) begin
            lane_data = wdata;
            lane_mask = {64{1'b1}};
        end else if (addr[2]) begin
            lane_data = {wdata[31:0], 32'h0};
            lane_mask = {{32{1'b1}}, 32'h0};
        end else begin
            lane_data = {32'h0, wdata[31:0]};
            lane_mask = {32'h0, {32{1'b1}}};
        end
    end

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             running
);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [CNT_W-1:0] count_q;

    // Next state: START / STOP on enable writes, otherwise HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALTED: begin
                if (en_wr && en_val) begin
                    state_d = CNT_RUNNING;
                end
            end
            CNT_RUNNING: begin
                if (en_wr && !en_val) begin
                    state_d = CNT_HALTED;
                end
            end
            default: state_d = CNT_HALTED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // Count register: load wins over a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (state_q == CNT_RUNNING && tick_en) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        count   = count_q;
        running = (state_q == CNT_RUNNING);
    end

    // R9
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HALTED && !load) |=> (count_q == $past(count_q)));

    // R7
    running_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUNNING && tick_en && !load) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));

endmodule

// File: rtl/evt_timer_readpath.sv
module evt_timer_readpath
    import evt_timer_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [63:0] CAPS  = 64'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic             acc_ok,
    input  rgn_e             rgn,
    input  logic             is_word,
    input  logic             hi_half,
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    input  logic [63:0]      ch_rd_data,
    output logic             rvalid,
    output logic [63:0]      rdata
);

    logic [63:0] sel64;
    logic [63:0] shaped;

    // Register select
    always_comb begin
        unique case (rgn)
            RGN_CAPS:  sel64 = CAPS;
            RGN_GCFG:  sel64 = {63'h0, running};
            RGN_COUNT: sel64 = {{(64-CNT_W){1'b0}}, count};
            RGN_TCFG:  sel64 = ch_rd_data;
            RGN_TCMP:  sel64 = ch_rd_data;
            default:   sel64 = 64'h0;
        endcase
    end

    // Size shaping: dropped accesses read zero, halves are zero-extended
    always_comb begin
        if (!acc_ok) begin
            shaped = 64'h0;
        end else if (is_word) begin
            shaped = sel64;
        end else if (hi_half) begin
            shaped = {32'h0, sel64[63:32]};
        end else begin
            shaped = {32'h0, sel64[31:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= 64'h0;
        end else begin
            rvalid <= rd_go;
            rdata  <= rd_go ? shaped : 64'h0;
        end
    end

    // R1 R2
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !acc_ok) |=> (rvalid && rdata == 64'h0));

    // R3
    half_read_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !is_word) |=> (rdata[63:32] == 32'h0));

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          N_TIMERS  = 8,
    parameter int          TICK_LOG2 = 24,
    parameter logic [15:0] VENDOR_ID = 16'h8086,
    parameter logic [7:0]  REVISION  = 8'h01,
    localparam int         IDX_W     = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
    localparam int         CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [3:0]        acc_size,
    input  logic [63:0]       acc_wdata,
    output logic              acc_rvalid,
    output logic [63:0]       acc_rdata,
    output logic [IDX_W-1:0]  ch_rd_idx,
    output logic              ch_rd_cfg,
    input  logic [63:0]       ch_rd_data,
    output logic              ch_wr_valid,
    output logic [IDX_W-1:0]  ch_wr_idx,
    output logic              ch_wr_cfg,
    output logic [63:0]       ch_wr_data,
    output logic [63:0]       ch_wr_mask,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              cnt_running
);

    localparam logic [31:0] PERIOD_FS = 32'(64'd1000000000000000 >> TICK_LOG2);
    localparam logic [63:0] CAPS_WORD = {PERIOD_FS, VENDOR_ID, 3'b000,
                                         5'(N_TIMERS - 1), REVISION};

    logic             acc_ok;
    rgn_e             rgn;
    logic [IDX_W-1:0] tmr_idx;
    logic             is_word;
    logic             hi_half;
    logic [63:0]      lane_data;
    logic [63:0]      lane_mask;
    logic             wr_go;
    logic             rd_go;
    logic             en_wr;
    logic             en_val;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             tmr_wr;

    evt_timer_decode #(
        .ADDR_W   (ADDR_W),
        .N_TIMERS (N_TIMERS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr      (acc_addr),
        .size      (acc_size),
        .wdata     (acc_wdata),
        .acc_ok    (acc_ok),
        .rgn       (rgn),
        .tmr_idx   (tmr_idx),
        .is_word   (is_word),
        .hi_half   (hi_half),
        .lane_data (lane_data),
        .lane_mask (lane_mask)
    );

    assign wr_go = acc_valid && acc_write && acc_ok;
    assign rd_go = acc_valid && !acc_write;

    // Configuration merge: only bit 0 is stored, legacy bit never kept
    assign en_wr  = wr_go && (rgn == RGN_GCFG);
    assign en_val = lane_mask[0] ? lane_data[0] : cnt_running;

    // Counter merge on the low 32 lanes (upper bits are zero-extension)
    assign cnt_load     = wr_go && (rgn == RGN_COUNT);
    assign cnt_load_val = (cnt_value & ~lane_mask[CNT_W-1:0]) |
                          (lane_data[CNT_W-1:0] & lane_mask[CNT_W-1:0]);

    evt_timer_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .en_wr    (en_wr),
        .en_val   (en_val),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .count    (cnt_value),
        .running  (cnt_running)
    );

    evt_timer_readpath #(
        .CNT_W (CNT_W),
        .CAPS  (CAPS_WORD)
    ) u_readpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_go      (rd_go),
        .acc_ok     (acc_ok),
        .rgn        (rgn),
        .is_word    (is_word),
        .hi_half    (hi_half),
        .running    (cnt_running),
        .count      (cnt_value),
        .ch_rd_data (ch_rd_data),
        .rvalid     (acc_rvalid),
        .rdata      (acc_rdata)
    );

    // Channel read select follows the current request
    assign ch_rd_idx = tmr_idx;
    assign ch_rd_cfg = (rgn == RGN_TCFG);

    // Channel write forwarding
    assign tmr_wr = wr_go && ((rgn == RGN_TCFG) || (rgn == RGN_TCMP));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_wr_valid <= 1'b0;
            ch_wr_idx   <= '0;
            ch_wr_cfg   <= 1'b0;
            ch_wr_data  <= 64'h0;
            ch_wr_mask  <= 64'h0;
        end else begin
            ch_wr_valid <= tmr_wr;
            if (tmr_wr) begin
                ch_wr_idx  <= tmr_idx;
                ch_wr_cfg  <= (rgn == RGN_TCFG);
                ch_wr_data <= lane_data;
                ch_wr_mask <= lane_mask;
            end
        end
    end

    // R1
    bad_size_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_size != 4'd4 && acc_size != 4'd8) |=> !ch_wr_valid);

    // R12
    read_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !ch_wr_valid);

    // R3
    fwd_mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wr_valid |-> (ch_wr_mask == {64{1'b1}} ||
                         ch_wr_mask == {{32{1'b1}}, 32'h0} ||
                         ch_wr_mask == {32'h0, {32{1'b1}}}));

    // R13
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> acc_rvalid);

endmodule

// File: tb/evt_timer_regs_test.sv
module evt_timer_regs_test;

    localparam int NT = 8;
    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        acc_valid;
    logic        acc_write;
    logic [AW-1:0] acc_addr;
    logic [3:0]  acc_size;
    logic [63:0] acc_wdata;
    logic        acc_rvalid;
    logic [63:0] acc_rdata;
    logic [2:0]  ch_rd_idx;
    logic        ch_rd_cfg;
    logic [63:0] ch_rd_data;
    logic        ch_wr_valid;
    logic [2:0]  ch_wr_idx;
    logic        ch_wr_cfg;
    logic [63:0] ch_wr_data;
    logic [63:0] ch_wr_mask;
    logic [31:0] cnt_value;
    logic        cnt_running;

    int checks = 0;
    int errors = 0;
    bit checking = 0;
    bit tick_on = 0;
    int tick_div = 3;
    int cyc = 0;
    string cur_req = "R13";

    always #2 clk = ~clk;

    // Channel stand-in: value depends on timer index and register kind
    function automatic logic [63:0] chan_val(input int n, input bit cfg);
        return {16'hC4A0, 8'(n), 7'h0, cfg, 32'h1234_0000 | 32'(n)};
    endfunction

    assign ch_rd_data = chan_val(int'(ch_rd_idx), ch_rd_cfg);

    evt_timer_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .acc_size    (acc_size),
        .acc_wdata   (acc_wdata),
        .acc_rvalid  (acc_rvalid),
        .acc_rdata   (acc_rdata),
        .ch_rd_idx   (ch_rd_idx),
        .ch_rd_cfg   (ch_rd_cfg),
        .ch_rd_data  (ch_rd_data),
        .ch_wr_valid (ch_wr_valid),
        .ch_wr_idx   (ch_wr_idx),
        .ch_wr_cfg   (ch_wr_cfg),
        .ch_wr_data  (ch_wr_data),
        .ch_wr_mask  (ch_wr_mask),
        .cnt_value   (cnt_value),
        .cnt_running (cnt_running)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference decode: 0 none, 1 caps, 2 config, 3 counter, 4 timer cfg, 5 timer cmp
    function automatic int region(input int a, output int n);
        int q;
        q = a & ~7;
        n = 0;
        if (q == 0)   return 1;
        if (q == 16)  return 2;
        if (q == 240) return 3;
        if (q >= 256 && q < 256 + 32 * NT) begin
            n = (q - 256) / 32;
            if ((q - 256) % 32 == 0) return 4;
            if ((q - 256) % 32 == 8) return 5;
        end
        return 0;
    endfunction

    // Behavioural reference model
    logic [31:0] m_count;
    bit          m_en;
    bit          exp_rv, exp_wv, exp_wcfg;
    int          exp_widx;
    logic [63:0] exp_rd, exp_wdata, exp_wmask;
    string       exp_req = "R13";
    logic [63:0] md, mm, mv, caps_ref;
    int          mr, mn, sz, ad;
    bit          mok, mld, mnew_en;

    initial caps_ref = ((64'd1000000000000000 / 64'd16777216) << 32) |
                       (64'h8086 << 16) | (64'(NT - 1) << 8) | 64'd1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0;
            m_en    = 0;
            exp_rv  = 0;
            exp_wv  = 0;
        end else begin
            sz = int'(acc_size);
            ad = int'(acc_addr);
            mok = (sz == 4 || sz == 8) && ((ad & (sz - 1)) == 0);
            mr = region(ad, mn);
            exp_req = cur_req;
            exp_rv = acc_valid && !acc_write;
            exp_wv = 0;
            if (exp_rv) begin
                case (mr)
                    1: mv = caps_ref;
                    2: mv = {63'h0, m_en};
                    3: mv = {32'h0, m_count};
                    4: mv = chan_val(mn, 1'b1);
                    5: mv = chan_val(mn, 1'b0);
                    default: mv = 64'h0;
                endcase
                if (!mok) mv = 64'h0;
                else if (sz == 4) mv = acc_addr[2] ? (mv >> 32) : (mv & 64'hFFFF_FFFF);
                exp_rd = mv;
            end else begin
                exp_rd = 64'h0;
            end
            if (sz == 8) begin
                md = acc_wdata; mm = '1;
            end else if (acc_addr[2]) begin
                md = acc_wdata << 32; mm = 64'hFFFF_FFFF_0000_0000;
            end else begin
                md = acc_wdata & 64'hFFFF_FFFF; mm = 64'hFFFF_FFFF;
            end
            mld = 0;
            mnew_en = m_en;
            if (acc_valid && acc_write && mok) begin
                if (mr == 2) begin
                    mv = ({63'h0, m_en} & ~mm) | (md & mm);
                    mnew_en = mv[0];
                end else if (mr == 3) begin
                    mv = ({32'h0, m_count} & ~mm) | (md & mm);
                    mld = 1;
                end else if (mr == 4 || mr == 5) begin
                    exp_wv = 1; exp_widx = mn; exp_wcfg = (mr == 4);
                    exp_wdata = md; exp_wmask = mm;
                end
            end
            if (mld) m_count = mv[31:0];
            else if (m_en && tick_en) m_count = m_count + 1;
            m_en = mnew_en;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            chk(cnt_value == m_count, "R7 R8 R9", "cnt_value", 64'(cnt_value), 64'(m_count));
            chk(cnt_running == m_en, "R9", "cnt_running", 64'(cnt_running), 64'(m_en));
            chk(acc_rvalid == exp_rv, "R13", "acc_rvalid", 64'(acc_rvalid), 64'(exp_rv));
            if (exp_rv)
                chk(acc_rdata == exp_rd, exp_req, "acc_rdata", acc_rdata, exp_rd);
            chk(ch_wr_valid == exp_wv, exp_req, "ch_wr_valid", 64'(ch_wr_valid), 64'(exp_wv));
            if (exp_wv && ch_wr_valid) begin
                chk(int'(ch_wr_idx) == exp_widx, "R10", "ch_wr_idx", 64'(ch_wr_idx), 64'(exp_widx));
                chk(ch_wr_cfg == exp_wcfg, "R10", "ch_wr_cfg", 64'(ch_wr_cfg), 64'(exp_wcfg));
                chk(ch_wr_data == exp_wdata, exp_req, "ch_wr_data", ch_wr_data, exp_wdata);
                chk(ch_wr_mask == exp_wmask, exp_req, "ch_wr_mask", ch_wr_mask, exp_wmask);
            end
        end
    end

    // Tick generator
    always @(negedge clk) begin
        tick_en = tick_on && (cyc % tick_div == 0);
        cyc++;
    end

    task automatic acc(input bit wr, input int addr, input logic [63:0] data,
                       input int size, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = AW'(addr);
        acc_wdata = data;
        acc_size  = 4'(size);
        cur_req   = req;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
        acc_size = 4'd8; acc_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(cnt_value == 0, "R13", "reset count", 64'(cnt_value), 0);
        chk(!cnt_running, "R13", "reset state", 64'(cnt_running), 0);
        chk(!acc_rvalid && !ch_wr_valid, "R13", "reset pulses",
            64'({acc_rvalid, ch_wr_valid}), 0);
        checking = 1;
        tick_on = 1;

        acc(0, 0, 0, 8, "R5");
        acc(0, 0, 0, 4, "R3");
        acc(0, 4, 0, 4, "R3");
        acc(0, 16, 0, 8, "R6");
        acc(1, 16, 64'h3, 8, "R6");
        acc(0, 16, 0, 8, "R6");
        idle(10);
        acc(0, 240, 0, 8, "R7");
        acc(0, 244, 0, 4, "R7");
        acc(1, 240, 64'hFFFF_FFFF_FFFF_FFF8, 8, "R8");
        tick_div = 1;
        idle(12);
        acc(0, 240, 0, 4, "R7");
        acc(1, 244, 64'h5555, 4, "R4");
        acc(1, 240, 64'hAAAA_0000_0000_0100, 4, "R4");
        acc(1, 16, 0, 4, "R9");
        idle(6);
        acc(0, 240, 0, 8, "R9");
        acc(1, 20, 64'h1, 4, "R4");
        acc(0, 16, 0, 8, "R4");
        acc(1, 16, 64'h1, 4, "R9");
        idle(4);
        acc(1, 240, 0, 2, "R1");
        acc(1, 240, 0, 1, "R1");
        acc(0, 240, 0, 2, "R1");
        acc(1, 16, 0, 0, "R1");
        acc(0, 0, 0, 16, "R1");
        acc(1, 244, 0, 8, "R2");
        acc(0, 244, 0, 8, "R2");
        acc(1, 242, 0, 4, "R2");
        acc(0, 2, 0, 4, "R2");
        acc(1, 256 + 264, 0, 8, "R2");
        acc(1, 256, 64'h1122_3344_5566_7788, 8, "R10");
        acc(1, 256 + 7 * 32 + 12, 64'hCAFE_BABE, 4, "R10");
        acc(1, 256 + 3 * 32 + 8, 64'hFFFF_FFFF_0BAD_F00D, 4, "R10");
        acc(1, 256 + 8 * 32, 64'h77, 8, "R12");
        acc(1, 256 + 16, 64'h77, 8, "R12");
        acc(1, 8, 64'h1234, 8, "R12");
        acc(0, 8, 0, 8, "R12");
        acc(0, 768, 0, 8, "R12");
        acc(0, 256 + 16, 0, 8, "R12");
        acc(0, 256 + 32 + 8, 0, 8, "R11");
        acc(0, 256 + 7 * 32 + 4, 0, 4, "R11");
        acc(0, 256 + 5 * 32, 0, 4, "R11");
        acc(1, 240, 64'h7, 8, "R8");
        acc(1, 16, 0, 8, "R9");
        idle(3);
        acc(1, 16, 64'h1, 8, "R9");
        idle(5);
        acc(0, 240, 0, 8, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R13 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule